// File: doc/BRIEF.md
# DRAM Reduced-Timing Characterisation Sequencer

This block drives a memory controller's command port to find how far one DRAM timing value can be shortened before stored data is corrupted. For each timing point it writes a batch of cache lines with pseudo-random data, touches every line once under the timing value being tried, and waits a programmable retention interval. It then reads every line back and counts the bits that differ from the regenerated pattern. The retention interval models a stretched refresh period, so that less charge is left in the cells.

A run covers an inclusive range of timing codes, stepping one code at a time, where one code equals 2.5 ns. Every line test of a batch is overlapped: all writes of the batch come first, then all accesses, then one shared wait, then all reads. The result of each timing point appears for one cycle on a result port, together with the temperature tag supplied at start. A host keeps the temperature at that tag.

Top module: `dram_margin_sweeper`

## Requirements
- R1: Reset holds the block idle: `busy`, `done`, `mem_cmd_valid` and `res_valid` are low.
- R2: Each timing point issues commands in strict phase order. First come the write beats, lines ascending from the base address with beats 0 to 7 within each line (op code 1). Next comes one access per line, ascending, at beat 0 (op code 2). After the wait come the read beats in the same order as the writes (op code 3). Line address = base + line index, modulo the address width.
- R3: Between the last access command and the first read command there are exactly ticks+1 cycles, where ticks = (interval code + 1) x 64 x `TICKS_PER_MS`. Interval code 0 gives the shortest interval, 64 ms, and code 7 gives 512 ms.
- R4: Write data comes from a 64-bit shift register that is loaded with the seed at the start of each point and shifts once per beat. The new state is {s[62:0], s[63]^s[62]^s[60]^s[59]}. A seed of zero is replaced by 1.
- R5: A batch holds `cfg_lines_m1`+1 lines, from 1 to 16.
- R6: A sweep tests every code from `cfg_lo` to `cfg_hi` inclusive, in increasing order. If `cfg_lo` > `cfg_hi`, only `cfg_lo` is tested. During each point, `mem_timing_sel` carries the parameter code and `mem_timing_val` carries the code under test. Parameter codes: 0 sensing delay, 1 read restore, 2 write restore, 3 precharge.
- R7: The error count of a point is the number of differing bits over all returned read beats, and it saturates at 2^`ERR_W`-1.
- R8: Each point ends with a one-cycle `res_valid` carrying the point index (from 0), the timing code, the error count and the temperature tag latched at start.
- R9: `start` is ignored while `busy` is high, and the configuration and results of the run in progress are unchanged.
- R10: After the last point `busy` falls and `done` rises. `done` stays high until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sweep (when idle) |
| cfg_param_sel | input | 2 | Timing parameter under test |
| cfg_lo | input | TVAL_W | First timing code (2.5 ns units) |
| cfg_hi | input | TVAL_W | Last timing code |
| cfg_lines_m1 | input | LINE_W | Lines per batch minus one |
| cfg_base | input | ADDR_W | First line address |
| cfg_interval_sel | input | 3 | Retention interval code |
| cfg_seed | input | 64 | Pattern seed |
| temp_tag | input | 7 | Test temperature in degrees C (55 to 85) |
| mem_cmd_valid | output | 1 | Command present |
| mem_cmd_op | output | 2 | 1 write, 2 access, 3 read |
| mem_cmd_addr | output | ADDR_W | Line address |
| mem_cmd_beat | output | 3 | Beat within the line |
| mem_wdata | output | 64 | Write beat data |
| mem_timing_sel | output | 2 | Parameter being reduced |
| mem_timing_val | output | TVAL_W | Reduced timing code |
| mem_rvalid | input | 1 | Read beat returned, in issue order |
| mem_rdata | input | 64 | Returned beat data |
| busy | output | 1 | Sweep running |
| done | output | 1 | Sweep finished |
| sweep_idx | output | TVAL_W | Current point index |
| res_valid | output | 1 | Result strobe |
| res_index | output | TVAL_W | Point index |
| res_timing | output | TVAL_W | Code of this point |
| res_errors | output | ERR_W | Bit error count |
| res_temp | output | 7 | Temperature tag |

## Verification
The memory model in the bench flips a number of low bits in each returned beat, and that number grows as the code falls below a per-parameter threshold. A sweep that crosses the threshold therefore separates points with zero errors from points with a known, growing count, and large batches far below the threshold push the count into saturation. Random runs vary the parameter, the range, the batch size, the base address (including wrap-around) and the seed. Directed runs cover a single-line batch, a full 16-line batch, the longest interval, a reversed range, a zero seed and a start pulse during a run. Together these show ordering faults, off-by-one waits, pattern drift and wrong result fields.

// File: rtl/dms_pkg.sv
// Shared types for the DRAM margin sweeper.
// Assumes a 64-bit beat and eight beats per cache line.
package dms_pkg;
    localparam int BEAT_BITS = 64;
    localparam int BEATS     = 8;
    localparam int BEAT_IW   = $clog2(BEATS);

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_ACCESS = 2'd2,
        OP_READ   = 2'd3
    } mem_op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_WRITE, S_ACCESS, S_WAIT, S_READ, S_DRAIN, S_REPORT
    } seq_state_e;
endpackage

// File: rtl/dms_lfsr.sv
// 64-bit Fibonacci shift register for the line pattern.
// Assumes the loaded value is non-zero; load wins over step.
module dms_lfsr (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [63:0] load_val,
    input  logic        step,
    output logic [63:0] q
);
    logic fb;

    // feedback taps for x^64 + x^63 + x^61 + x^60 + 1
    always_comb fb = q[63] ^ q[62] ^ q[60] ^ q[59];

    // load the seed or shift one position
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 64'h1;
        else if (load) q <= load_val;
        else if (step) q <= {q[62:0], fb};
    end

    // R4: the pattern never reaches the all-zero lock-up state
    a_r4_never_zero: assert property (@(posedge clk) disable iff (!rst_n) q != 64'h0);
endmodule

// File: rtl/dms_wait_timer.sv
// Retention-interval down counter.
// Loaded with a tick count of at least 1; `last` marks the final tick while running.
module dms_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    // final tick when one count remains
    always_comb last = (cnt <= CNT_W'(1));

    // count down once per running cycle
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (load)            cnt <= load_val;
        else if (run && !last)    cnt <= cnt - CNT_W'(1);
    end

    // R3: each waiting cycle removes exactly one tick
    a_r3_tick_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last && !load) |=> cnt == $past(cnt) - CNT_W'(1));
endmodule

// File: rtl/dms_err_acc.sv
// Saturating accumulator of mismatching bits between two beats.
// Assumes clr and en are never high together.
module dms_err_acc #(
    parameter int W     = 64,
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [W-1:0]     got,
    input  logic [W-1:0]     want,
    output logic [ERR_W-1:0] cnt
);
    localparam int POP_W = $clog2(W + 1);
    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    logic [POP_W-1:0] pop;
    logic [ERR_W+POP_W-1:0] sum;

    // population count of the differing bits
    always_comb begin
        pop = '0;
        for (int i = 0; i < W; i++) pop = pop + POP_W'(got[i] ^ want[i]);
        sum = {{POP_W{1'b0}}, cnt} + {{ERR_W{1'b0}}, pop};
    end

    // clear per point, add with saturation
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (en)       cnt <= (sum > {{POP_W{1'b0}}, CNT_MAX}) ? CNT_MAX : sum[ERR_W-1:0];
    end

    // R7: the count never wraps back down between clears
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt >= $past(cnt));
    // R7: a saturated count stays at its ceiling
    a_r7_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt == CNT_MAX) |=> cnt == CNT_MAX);
endmodule

// File: rtl/dram_margin_sweeper.sv
// Sweeps one DRAM timing code over a range. For each point it writes a batch of
// lines, accesses them at the reduced timing, waits a retention interval, reads
// them back and counts bit errors. Assumes read beats return in issue order and
// that the memory accepts one command per cycle.
module dram_margin_sweeper #(
    parameter int ADDR_W       = 24,
    parameter int TVAL_W       = 8,
    parameter int ERR_W        = 16,
    parameter int LINE_W       = 4,
    parameter int TICKS_PER_MS = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cfg_param_sel,
    input  logic [TVAL_W-1:0] cfg_lo,
    input  logic [TVAL_W-1:0] cfg_hi,
    input  logic [LINE_W-1:0] cfg_lines_m1,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [2:0]        cfg_interval_sel,
    input  logic [63:0]       cfg_seed,
    input  logic [6:0]        temp_tag,
    output logic              mem_cmd_valid,
    output logic [1:0]        mem_cmd_op,
    output logic [ADDR_W-1:0] mem_cmd_addr,
    output logic [2:0]        mem_cmd_beat,
    output logic [63:0]       mem_wdata,
    output logic [1:0]        mem_timing_sel,
    output logic [TVAL_W-1:0] mem_timing_val,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [TVAL_W-1:0] sweep_idx,
    output logic              res_valid,
    output logic [TVAL_W-1:0] res_index,
    output logic [TVAL_W-1:0] res_timing,
    output logic [ERR_W-1:0]  res_errors,
    output logic [6:0]        res_temp
);
    import dms_pkg::*;

    localparam int CNT_W   = $clog2(512 * TICKS_PER_MS + 1);
    localparam int RX_W    = LINE_W + BEAT_IW + 1;
    localparam logic [BEAT_IW-1:0] BEAT_LAST = BEAT_IW'(BEATS - 1);

    seq_state_e        state;
    logic [LINE_W-1:0] line_q, nl_q;
    logic [BEAT_IW-1:0] beat_q;
    logic [ADDR_W-1:0] base_q;
    logic [TVAL_W-1:0] tval_q, hi_q, idx_q;
    logic [1:0]        sel_q;
    logic [2:0]        isel_q;
    logic [63:0]       seed_q;
    logic [6:0]        temp_q;
    logic [RX_W-1:0]   rx_cnt, rx_total;
    logic [CNT_W-1:0]  ticks;
    logic [63:0]       pat, seed_in;
    logic              accept, line_end, batch_end, tmr_last, wait_end, more_points;
    mem_op_e           op;

    // decode of handy conditions
    always_comb begin
        accept      = (state == S_IDLE) && start;
        line_end    = (beat_q == BEAT_LAST);
        batch_end   = (line_q == nl_q);
        wait_end    = (state == S_WAIT) && tmr_last;
        more_points = (tval_q < hi_q);
        rx_total    = RX_W'((32'(nl_q) + 1) * BEATS);
        ticks       = CNT_W'((32'(isel_q) + 1) * 64 * TICKS_PER_MS);
        seed_in     = (cfg_seed == 64'h0) ? 64'h1 : cfg_seed;
    end

    // sequencing of phases and sweep points
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            line_q <= '0;
            beat_q <= '0;
            nl_q   <= '0;
            base_q <= '0;
            tval_q <= '0;
            hi_q   <= '0;
            idx_q  <= '0;
            sel_q  <= '0;
            isel_q <= '0;
            seed_q <= 64'h1;
            temp_q <= '0;
            done   <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    nl_q   <= cfg_lines_m1;
                    base_q <= cfg_base;
                    tval_q <= cfg_lo;
                    hi_q   <= cfg_hi;
                    idx_q  <= '0;
                    sel_q  <= cfg_param_sel;
                    isel_q <= cfg_interval_sel;
                    seed_q <= seed_in;
                    temp_q <= temp_tag;
                    line_q <= '0;
                    beat_q <= '0;
                    done   <= 1'b0;
                    state  <= S_WRITE;
                end
                S_WRITE, S_READ: begin
                    beat_q <= beat_q + BEAT_IW'(1);
                    if (line_end) begin
                        beat_q <= '0;
                        line_q <= batch_end ? '0 : line_q + LINE_W'(1);
                        if (batch_end) state <= (state == S_WRITE) ? S_ACCESS : S_DRAIN;
                    end
                end
                S_ACCESS: begin
                    line_q <= batch_end ? '0 : line_q + LINE_W'(1);
                    if (batch_end) state <= S_WAIT;
                end
                S_WAIT: if (tmr_last) state <= S_READ;
                S_DRAIN: if (rx_cnt == rx_total) state <= S_REPORT;
                S_REPORT: begin
                    if (more_points) begin
                        tval_q <= tval_q + TVAL_W'(1);
                        idx_q  <= idx_q + TVAL_W'(1);
                        state  <= S_WRITE;
                    end else begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // count returned read beats of the current point
    always_ff @(posedge clk) begin
        if (!rst_n || wait_end) rx_cnt <= '0;
        else if (mem_rvalid)    rx_cnt <= rx_cnt + RX_W'(1);
    end

    dms_lfsr u_pat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept || wait_end || (state == S_REPORT && more_points)),
        .load_val (accept ? seed_in : seed_q),
        .step     ((state == S_WRITE) || mem_rvalid),
        .q        (pat)
    );

    dms_wait_timer #(.CNT_W(CNT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     ((state == S_ACCESS) && batch_end),
        .load_val (ticks),
        .run      (state == S_WAIT),
        .last     (tmr_last)
    );

    dms_err_acc #(.W(BEAT_BITS), .ERR_W(ERR_W)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wait_end),
        .en    (mem_rvalid && (state == S_READ || state == S_DRAIN)),
        .got   (mem_rdata),
        .want  (pat),
        .cnt   (res_errors)
    );

    // command port and status outputs
    always_comb begin
        case (state)
            S_WRITE:  op = OP_WRITE;
            S_ACCESS: op = OP_ACCESS;
            S_READ:   op = OP_READ;
            default:  op = OP_NONE;
        endcase
        mem_cmd_valid  = (op != OP_NONE);
        mem_cmd_op     = op;
        mem_cmd_addr   = base_q + ADDR_W'(line_q);
        mem_cmd_beat   = (state == S_ACCESS) ? 3'd0 : 3'(beat_q);
        mem_wdata      = (state == S_WRITE) ? pat : 64'h0;
        mem_timing_sel = sel_q;
        mem_timing_val = tval_q;
        busy           = (state != S_IDLE);
        sweep_idx      = idx_q;
        res_valid      = (state == S_REPORT);
        res_index      = idx_q;
        res_timing     = tval_q;
        res_temp       = temp_q;
    end

    // R1: no command leaves an idle block
    a_r1_cmd_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |-> busy);
    // R2: reads start only once the retention wait is over
    a_r2_read_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ && $past(state) != S_READ) |-> $past(state) == S_WAIT);
    // R6: each further point advances the code by exactly one step
    a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REPORT && more_points) |=> tval_q == $past(tval_q) + TVAL_W'(1));
    // R9: a start during a run leaves the point and its setup untouched
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && state != S_REPORT) |=> ($stable(tval_q) && $stable(base_q) && $stable(temp_q)));
endmodule

// File: tb/sim_dram_margin_sweeper.sv
module sim_dram_margin_sweeper;
    localparam int AW = 8;
    localparam int TW = 8;
    localparam int EW = 10;
    localparam int EMAX = (1 << EW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] cfg_param_sel = '0;
    logic [TW-1:0] cfg_lo = '0, cfg_hi = '0;
    logic [3:0] cfg_lines_m1 = '0;
    logic [AW-1:0] cfg_base = '0;
    logic [2:0] cfg_interval_sel = '0;
    logic [63:0] cfg_seed = '0;
    logic [6:0] temp_tag = '0;
    logic mem_cmd_valid, busy, done, res_valid;
    logic [1:0] mem_cmd_op, mem_timing_sel;
    logic [AW-1:0] mem_cmd_addr;
    logic [2:0] mem_cmd_beat;
    logic [63:0] mem_wdata;
    logic [TW-1:0] mem_timing_val, sweep_idx, res_index, res_timing;
    logic mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic [EW-1:0] res_errors;
    logic [6:0] res_temp;

    always #2 clk = ~clk;

    dram_margin_sweeper #(.ADDR_W(AW), .TVAL_W(TW), .ERR_W(EW), .LINE_W(4), .TICKS_PER_MS(1)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_param_sel(cfg_param_sel),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_lines_m1(cfg_lines_m1), .cfg_base(cfg_base),
        .cfg_interval_sel(cfg_interval_sel), .cfg_seed(cfg_seed), .temp_tag(temp_tag),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_op(mem_cmd_op), .mem_cmd_addr(mem_cmd_addr),
        .mem_cmd_beat(mem_cmd_beat), .mem_wdata(mem_wdata), .mem_timing_sel(mem_timing_sel),
        .mem_timing_val(mem_timing_val), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .sweep_idx(sweep_idx), .res_valid(res_valid),
        .res_index(res_index), .res_timing(res_timing), .res_errors(res_errors), .res_temp(res_temp));

    int n_checks = 0, n_fail = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected results come from these bench functions
    function automatic logic [63:0] pat_next(input logic [63:0] s);
        return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
    endfunction
    function automatic int thr_of(input int sel);
        case (sel)
            0: return 20;
            1: return 30;
            2: return 25;
            default: return 40;
        endcase
    endfunction
    function automatic int flips(input int sel, input int tv);
        int k;
        k = (thr_of(sel) > tv) ? thr_of(sel) - tv : 0;
        return (k > 64) ? 64 : k;
    endfunction
    function automatic logic [63:0] fmask(input int k);
        return (k >= 64) ? '1 : ((64'h1 << k) - 64'h1);
    endfunction
    function automatic int exp_err(input int sel, input int tv, input int nlines);
        int t;
        t = nlines * 8 * flips(sel, tv);
        return (t > EMAX) ? EMAX : t;
    endfunction

    // expectation of the run in progress
    int e_sel, e_lo, e_hi, e_nl, e_base, e_isel, e_temp, e_pts;
    logic [63:0] e_seed;
    int res_seen = 0;

    // memory model and step monitor state
    logic [63:0] mem [0:2047];
    int acc_tv [0:255];
    logic p1v = 0, p2v = 0;
    logic [63:0] p1d = '0, p2d = '0;
    int wr_n = 0, ac_n = 0, rd_n = 0, ph = 0;
    int ord_err = 0, adr_err = 0, dat_err = 0, tsel_err = 0;
    int last_ac = 0, first_rd = 0;
    logic [63:0] exp_w = '0;

    // model the memory and observe the command port away from the clock edge
    always @(negedge clk) begin
        int ln, idx;
        cyc++;
        mem_rvalid = p2v; mem_rdata = p2d;
        p2v = p1v; p2d = p1d; p1v = 0;
        if (rst_n && mem_cmd_valid) begin
            if (int'(mem_cmd_op) < ph) ord_err++;
            ph = int'(mem_cmd_op);
            if (int'(mem_timing_sel) != e_sel || int'(mem_timing_val) != e_lo + res_seen) tsel_err++;
            idx = int'({mem_cmd_addr, mem_cmd_beat});
            case (mem_cmd_op)
                2'd1: begin
                    ln = wr_n / 8;
                    if (int'(mem_cmd_addr) != ((e_base + ln) % 256) || int'(mem_cmd_beat) != wr_n % 8) adr_err++;
                    exp_w = (wr_n == 0) ? e_seed : pat_next(exp_w);
                    if (mem_wdata != exp_w) dat_err++;
                    mem[idx] = mem_wdata;
                    wr_n++;
                end
                2'd2: begin
                    if (int'(mem_cmd_addr) != ((e_base + ac_n) % 256) || mem_cmd_beat != 3'd0) adr_err++;
                    acc_tv[mem_cmd_addr] = int'(mem_timing_val);
                    ac_n++;
                    last_ac = cyc;
                end
                2'd3: begin
                    ln = rd_n / 8;
                    if (int'(mem_cmd_addr) != ((e_base + ln) % 256) || int'(mem_cmd_beat) != rd_n % 8) adr_err++;
                    if (rd_n == 0) first_rd = cyc;
                    p1v = 1;
                    p1d = mem[idx] ^ fmask(flips(e_sel, acc_tv[mem_cmd_addr]));
                    rd_n++;
                end
                default: ord_err++;
            endcase
        end
        if (rst_n && res_valid) begin
            chk(int'(res_index) == res_seen, "R8 index", res_index, res_seen);
            chk(int'(res_timing) == e_lo + res_seen, "R6 code", res_timing, e_lo + res_seen);
            chk(int'(res_temp) == e_temp, "R8 temp", res_temp, e_temp);
            chk(int'(res_errors) == exp_err(e_sel, e_lo + res_seen, e_nl), "R7 errors", res_errors,
                exp_err(e_sel, e_lo + res_seen, e_nl));
            chk(wr_n == e_nl * 8 && rd_n == e_nl * 8 && ac_n == e_nl, "R5 batch size", wr_n, e_nl * 8);
            chk(ord_err == 0 && adr_err == 0, "R2 order/address", ord_err + adr_err, 0);
            chk(first_rd - last_ac == (e_isel + 1) * 64 + 1, "R3 wait", first_rd - last_ac, (e_isel + 1) * 64 + 1);
            chk(dat_err == 0, "R4 pattern", dat_err, 0);
            chk(tsel_err == 0, "R6 timing port", tsel_err, 0);
            res_seen++;
            wr_n = 0; ac_n = 0; rd_n = 0; ph = 0;
            ord_err = 0; adr_err = 0; dat_err = 0; tsel_err = 0;
        end
    end

    task automatic run(input int sel, input int lo, input int hi, input int nl, input int base,
                       input int isel, input logic [63:0] seed, input int temp, input bit poke);
        e_sel = sel; e_lo = lo; e_hi = hi; e_nl = nl; e_base = base; e_isel = isel;
        e_temp = temp; e_seed = (seed == 0) ? 64'h1 : seed;
        e_pts = (hi >= lo) ? hi - lo + 1 : 1;
        res_seen = 0;
        @(negedge clk);
        cfg_param_sel = 2'(sel); cfg_lo = TW'(lo); cfg_hi = TW'(hi);
        cfg_lines_m1 = 4'(nl - 1); cfg_base = AW'(base); cfg_interval_sel = 3'(isel);
        cfg_seed = seed; temp_tag = 7'(temp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done, "R10 done cleared on start", done, 0);
        if (poke) begin
            repeat (40) @(negedge clk);
            cfg_lo = TW'(lo + 7); cfg_base = AW'(base + 3); temp_tag = 7'(temp + 1); cfg_param_sel = ~cfg_param_sel;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R9 start while busy", busy, 1);
        end
        while (busy) @(negedge clk);
        chk(res_seen == e_pts, "R6 point count", res_seen, e_pts);
        chk(done && !busy, "R10 done after sweep", done, 1);
    endtask

    initial begin
        int s;
        s = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_cmd_valid && !res_valid, "R1 reset state", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_cmd_valid, "R1 idle after reset", mem_cmd_valid, 0);
        // directed corners
        run(0, 17, 21, 1, 10, 0, 64'hDEAD_BEEF_0123_4567, 55, 0);    // single line, crosses threshold
        run(3, 2, 4, 16, 250, 7, 64'h0, 85, 0);                      // full batch, longest wait, zero seed, saturation
        run(1, 33, 29, 3, 0, 1, 64'h5555, 65, 0);                    // reversed range
        run(2, 22, 26, 4, 100, 0, 64'h1357_9BDF_2468_ACE0, 75, 1);   // start while busy
        // constrained random runs
        for (int r = 0; r < 6; r++) begin
            int sel, lo;
            sel = int'($urandom_range(0, 3));
            lo = thr_of(sel) - int'($urandom_range(0, 6));
            run(sel, lo, lo + int'($urandom_range(0, 4)), int'($urandom_range(1, 16)),
                int'($urandom_range(0, 255)), int'($urandom_range(0, 2)),
                {$urandom, $urandom}, int'($urandom_range(55, 85)), 0);
        end
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule